// File: doc/BRIEF.md
# DMA Coherent Transaction Controller

This block sits between a DMA engine's request sequencer and a directory-based coherence fabric. It accepts one load or store at a time from the sequencer and turns it into a read or write request toward the directory. It then follows the transaction until it completes, and reports either the returned line data or a write-complete pulse back to the sequencer.

Completion of a write is decided by a signed acknowledgement balance. A memory acknowledgement can carry a negative count that raises the number of expected invalidation acks, and each ack-bearing response subtracts its count from the balance. When the balance reaches zero, an internal completion trigger is posted. The trigger is taken on a later cycle and, for a write, sends an exclusive-unblock message back to the directory. Both outgoing ports hold each message for a programmable latency before presenting it.

Top module: `dmx_dma_ctrl`

## Requirements
- R1: After reset the controller is idle: `seq_ready` is 1, and `req_valid`, `unb_valid`, `rd_done`, `wr_done`, `err_seq` and `err_rsp` are 0.
- R2: A sequencer request is accepted in idle. A load (`seq_kind`=0) produces a directory request with `req_kind`=0, and a store (`seq_kind`=1) produces one with `req_kind`=1. The request carries the accepted address, length and data, and `req_src` equals the `SRC_ID` parameter.
- R3: The directory request becomes valid exactly `REQ_LAT` cycles after the acceptance edge. It stays valid, with a stable payload, until it is taken with `req_ready`.
- R4: While a transaction is open, or while the request slot still holds a message, `seq_ready` is 0 and the sequencer request waits at the input.
- R5: A sequencer kind of 2 or 3 is accepted in idle and gives a one-cycle `err_seq` pulse. It opens no transaction, and `seq_ready` stays 1.
- R6: Response kinds are decoded as 0 memory ack, 1 data, 2 exclusive data and 3 invalidation ack. Kinds 4 to 7 are accepted in any state without a pending trigger, give a one-cycle `err_rsp` pulse and have no other effect.
- R7: The ack balance is a signed `CW`-bit value that is cleared when a transaction opens. Each accepted memory ack or invalidation ack subtracts its `rsp_acks` value. If the result is zero, a completion trigger is posted, and `rsp_ready` is 0 while that trigger is pending.
- R8: In a read, an accepted data or exclusive-data response makes `rd_done` pulse on the cycle after acceptance, with that response's data on `rd_data`. The controller then returns to idle.
- R9: In a read, a completion trigger reached through invalidation acks makes `rd_done` pulse with the transaction's held data. That data is all zeros when no data response arrived. The controller returns to idle.
- R10: In a write, the trigger is taken only when the unblock slot is empty. Taking it makes `wr_done` pulse on the next cycle and presents an unblock carrying the transaction address on `unb_addr`, exactly `RSP_LAT` cycles after the take edge. The unblock is held until `unb_ready`.
- R11: A legal response kind that the current state does not handle is not accepted (`rsp_ready` is 0). This covers data during a write, a memory ack during a read, and any legal kind in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seq_valid | input | 1 | Sequencer request valid |
| seq_ready | output | 1 | Sequencer request accepted this cycle when valid |
| seq_kind | input | 2 | 0 load, 1 store, 2-3 illegal |
| seq_addr | input | AW | Physical address |
| seq_len | input | LW | Transfer length |
| seq_data | input | DW | Store data block |
| req_valid | output | 1 | Directory request valid |
| req_ready | input | 1 | Directory takes the request |
| req_kind | output | 1 | 0 read, 1 write |
| req_addr | output | AW | Request address |
| req_len | output | LW | Request length |
| req_data | output | DW | Request data block |
| req_src | output | IDW | Requester identity |
| rsp_valid | input | 1 | Incoming response valid |
| rsp_ready | output | 1 | Incoming response accepted |
| rsp_kind | input | 3 | Response kind code |
| rsp_acks | input | CW | Signed ack count carried by the response |
| rsp_data | input | DW | Response data block |
| unb_valid | output | 1 | Exclusive-unblock message valid |
| unb_ready | input | 1 | Directory takes the unblock |
| unb_addr | output | AW | Unblock address |
| rd_done | output | 1 | Read complete pulse to the sequencer |
| rd_data | output | DW | Read data returned |
| wr_done | output | 1 | Write complete pulse to the sequencer |
| err_seq | output | 1 | Illegal sequencer kind pulse |
| err_rsp | output | 1 | Illegal response kind pulse |

## Verification
The bound checker watches several properties on every cycle. Directory requests and unblocks stay stable while back-pressured. The sequencer is refused whenever a transaction is open, and responses are refused while a completion trigger waits. A write-complete pulse always coincides with an occupied unblock slot, and the two completion pulses never overlap. The exact latencies, the arithmetic of the signed ack balance (including a negative memory ack followed by invalidation acks), the data returned on each read path, and the stall of the trigger behind an occupied unblock slot are shown only by the bench scenarios. There, a behavioural model is compared against every output on every cycle.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_WR_WAIT = 2'd2
    } dmx_state_e;

    localparam logic [1:0] SEQ_LOAD  = 2'd0;
    localparam logic [1:0] SEQ_STORE = 2'd1;

    localparam logic [2:0] RSP_MEM_ACK = 3'd0;
    localparam logic [2:0] RSP_DATA    = 3'd1;
    localparam logic [2:0] RSP_DATA_EX = 3'd2;
    localparam logic [2:0] RSP_INV_ACK = 3'd3;

    typedef enum logic [1:0] {
        EV_MEM_ACK = 2'd0,
        EV_DATA    = 2'd1,
        EV_INV_ACK = 2'd2,
        EV_BAD     = 2'd3
    } dmx_event_e;

    function automatic dmx_event_e decode_rsp(input logic [2:0] kind);
        case (kind)
            RSP_MEM_ACK:           return EV_MEM_ACK;
            RSP_DATA, RSP_DATA_EX: return EV_DATA;
            RSP_INV_ACK:           return EV_INV_ACK;
            default:               return EV_BAD;
        endcase
    endfunction

endpackage

// File: rtl/dmx_delay_slot.sv
module dmx_delay_slot #(
    parameter int W   = 8,
    parameter int LAT = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_data_i,
    output logic         out_valid_o,
    input  logic         out_ready_i,
    output logic [W-1:0] out_data_o,
    output logic         busy_o
);
    localparam int CNTW = (LAT < 1) ? 1 : $clog2(LAT + 1);
    localparam logic [CNTW-1:0] LAT_C = CNTW'(LAT);

    typedef struct packed {
        logic            full;
        logic [CNTW-1:0] dly;
        logic [W-1:0]    data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (load_i) begin
            slot_d.full = 1'b1;
            slot_d.dly  = LAT_C;
            slot_d.data = load_data_i;
        end else if (slot_q.full) begin
            if (slot_q.dly != '0) begin
                slot_d.dly = slot_q.dly - 1'b1;
            end else if (out_ready_i) begin
                slot_d.full = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign out_valid_o = slot_q.full && (slot_q.dly == '0);
    assign out_data_o  = slot_q.data;
    assign busy_o      = slot_q.full;

endmodule

// File: rtl/dmx_ack_tracker.sv
module dmx_ack_tracker #(
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 apply_i,
    input  logic signed [CW-1:0] delta_i,
    input  logic                 take_i,
    output logic                 pend_o
);
    typedef struct packed {
        logic signed [CW-1:0] bal;
        logic                 pend;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (clear_i) begin
            trk_d.bal  = '0;
            trk_d.pend = 1'b0;
        end else begin
            if (apply_i) begin
                trk_d.bal = trk_q.bal - delta_i;
                if (trk_d.bal == '0) trk_d.pend = 1'b1;
            end
            if (take_i) trk_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign pend_o = trk_q.pend;

endmodule

// File: rtl/dmx_dma_ctrl.sv
module dmx_dma_ctrl
    import dmx_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 64,
    parameter int LW      = 8,
    parameter int CW      = 8,
    parameter int IDW     = 4,
    parameter logic [IDW-1:0] SRC_ID = 4'd5,
    parameter int REQ_LAT = 14,
    parameter int RSP_LAT = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seq_valid,
    output logic                 seq_ready,
    input  logic [1:0]           seq_kind,
    input  logic [AW-1:0]        seq_addr,
    input  logic [LW-1:0]        seq_len,
    input  logic [DW-1:0]        seq_data,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic                 req_kind,
    output logic [AW-1:0]        req_addr,
    output logic [LW-1:0]        req_len,
    output logic [DW-1:0]        req_data,
    output logic [IDW-1:0]       req_src,
    input  logic                 rsp_valid,
    output logic                 rsp_ready,
    input  logic [2:0]           rsp_kind,
    input  logic signed [CW-1:0] rsp_acks,
    input  logic [DW-1:0]        rsp_data,
    output logic                 unb_valid,
    input  logic                 unb_ready,
    output logic [AW-1:0]        unb_addr,
    output logic                 rd_done,
    output logic [DW-1:0]        rd_data,
    output logic                 wr_done,
    output logic                 err_seq,
    output logic                 err_rsp
);
    localparam int REQ_W = 1 + AW + LW + DW;

    typedef struct packed {
        dmx_state_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] hold;
        logic          rd_done;
        logic          wr_done;
        logic          err_seq;
        logic          err_rsp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    dmx_state_e cur_state;
    dmx_event_e ev;
    logic       trig_pend, unb_busy, req_busy;
    logic       rsp_handled, rsp_fire, ack_apply, trig_take;
    logic       seq_fire, seq_good, req_load, unb_load;
    logic [REQ_W-1:0] req_payload;

    assign cur_state = ctl_q.st;
    assign ev        = decode_rsp(rsp_kind);

    always_comb begin
        rsp_handled = 1'b0;
        case (cur_state)
            ST_RD_WAIT: rsp_handled = (ev == EV_DATA) || (ev == EV_INV_ACK);
            ST_WR_WAIT: rsp_handled = (ev == EV_MEM_ACK) || (ev == EV_INV_ACK);
            default:    rsp_handled = 1'b0;
        endcase
        if (ev == EV_BAD) rsp_handled = 1'b1;
    end

    assign rsp_ready = !trig_pend && rsp_handled;
    assign rsp_fire  = rsp_valid && rsp_ready;
    assign ack_apply = rsp_fire && ((ev == EV_MEM_ACK) || (ev == EV_INV_ACK));
    assign trig_take = trig_pend &&
                       ((cur_state == ST_RD_WAIT) || ((cur_state == ST_WR_WAIT) && !unb_busy));
    assign seq_ready = (cur_state == ST_IDLE) && !req_busy;
    assign seq_fire  = seq_valid && seq_ready;
    assign seq_good  = (seq_kind == SEQ_LOAD) || (seq_kind == SEQ_STORE);
    assign req_load  = seq_fire && seq_good;
    assign unb_load  = trig_take && (cur_state == ST_WR_WAIT);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rd_done = 1'b0;
        ctl_d.wr_done = 1'b0;
        ctl_d.err_seq = 1'b0;
        ctl_d.err_rsp = rsp_fire && (ev == EV_BAD);
        case (cur_state)
            ST_IDLE: begin
                if (seq_fire) begin
                    if (seq_kind == SEQ_LOAD) begin
                        ctl_d.st   = ST_RD_WAIT;
                        ctl_d.addr = seq_addr;
                        ctl_d.hold = '0;
                    end else if (seq_kind == SEQ_STORE) begin
                        ctl_d.st   = ST_WR_WAIT;
                        ctl_d.addr = seq_addr;
                    end else begin
                        ctl_d.err_seq = 1'b1;
                    end
                end
            end
            ST_RD_WAIT: begin
                if (rsp_fire && (ev == EV_DATA)) begin
                    ctl_d.hold    = rsp_data;
                    ctl_d.rd_done = 1'b1;
                    ctl_d.st      = ST_IDLE;
                end else if (trig_take) begin
                    ctl_d.rd_done = 1'b1;
                    ctl_d.st      = ST_IDLE;
                end
            end
            ST_WR_WAIT: begin
                if (trig_take) begin
                    ctl_d.wr_done = 1'b1;
                    ctl_d.st      = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dmx_ack_tracker #(.CW(CW)) trk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (req_load),
        .apply_i (ack_apply),
        .delta_i (rsp_acks),
        .take_i  (trig_take),
        .pend_o  (trig_pend)
    );

    dmx_delay_slot #(.W(REQ_W), .LAT(REQ_LAT)) req_slot_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (req_load),
        .load_data_i ({(seq_kind == SEQ_STORE), seq_addr, seq_len, seq_data}),
        .out_valid_o (req_valid),
        .out_ready_i (req_ready),
        .out_data_o  (req_payload),
        .busy_o      (req_busy)
    );

    dmx_delay_slot #(.W(AW), .LAT(RSP_LAT)) unb_slot_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (unb_load),
        .load_data_i (ctl_q.addr),
        .out_valid_o (unb_valid),
        .out_ready_i (unb_ready),
        .out_data_o  (unb_addr),
        .busy_o      (unb_busy)
    );

    assign {req_kind, req_addr, req_len, req_data} = req_payload;
    assign req_src = SRC_ID;
    assign rd_done = ctl_q.rd_done;
    assign rd_data = ctl_q.hold;
    assign wr_done = ctl_q.wr_done;
    assign err_seq = ctl_q.err_seq;
    assign err_rsp = ctl_q.err_rsp;

endmodule

// File: rtl/dmx_dma_ctrl_chk.sv
module dmx_dma_ctrl_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    state_i,
    input logic          seq_ready,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          rsp_ready,
    input logic          trig_pend,
    input logic          unb_valid,
    input logic          unb_ready,
    input logic [AW-1:0] unb_addr,
    input logic          unb_busy,
    input logic          rd_done,
    input logic          wr_done
);
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    p_busy_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != 2'd0) |-> !seq_ready);

    p_trig_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pend |-> !rsp_ready);

    p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (state_i == 2'd0));

    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && wr_done));

    p_wr_unb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> unb_busy);

    p_unb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (unb_valid && !unb_ready) |=> (unb_valid && $stable(unb_addr)));

endmodule

bind dmx_dma_ctrl dmx_dma_ctrl_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_i   (cur_state),
    .seq_ready (seq_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_ready (rsp_ready),
    .trig_pend (trig_pend),
    .unb_valid (unb_valid),
    .unb_ready (unb_ready),
    .unb_addr  (unb_addr),
    .unb_busy  (unb_busy),
    .rd_done   (rd_done),
    .wr_done   (wr_done)
);

// File: tb/dmx_dma_ctrl_tb_top.sv
`timescale 1ns/1ps
module dmx_dma_ctrl_tb_top;
    localparam int LATQ = 14;
    localparam int LATU = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        seq_valid = 0, seq_ready;
    logic [1:0]  seq_kind = 0;
    logic [31:0] seq_addr = 0;
    logic [7:0]  seq_len = 0;
    logic [63:0] seq_data = 0;
    logic        req_valid, req_ready = 1, req_kind;
    logic [31:0] req_addr;
    logic [7:0]  req_len;
    logic [63:0] req_data;
    logic [3:0]  req_src;
    logic        rsp_valid = 0, rsp_ready;
    logic [2:0]  rsp_kind = 0;
    logic signed [7:0] rsp_acks = 0;
    logic [63:0] rsp_data = 0;
    logic        unb_valid, unb_ready = 1;
    logic [31:0] unb_addr;
    logic        rd_done, wr_done, err_seq, err_rsp;
    logic [63:0] rd_data;

    dmx_dma_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_kind(seq_kind),
        .seq_addr(seq_addr), .seq_len(seq_len), .seq_data(seq_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len), .req_data(req_data), .req_src(req_src),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
        .rsp_acks(rsp_acks), .rsp_data(rsp_data),
        .unb_valid(unb_valid), .unb_ready(unb_ready), .unb_addr(unb_addr),
        .rd_done(rd_done), .rd_data(rd_data), .wr_done(wr_done),
        .err_seq(err_seq), .err_rsp(err_rsp)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_st;          // 0 idle, 1 read, 2 write
    logic signed [7:0] m_bal;
    bit          m_trig;
    logic [31:0] m_taddr;
    logic [63:0] m_hold;
    bit          m_rq_full;
    int          m_rq_wait;
    bit          m_rq_kind;
    logic [31:0] m_rq_addr;
    logic [7:0]  m_rq_len;
    logic [63:0] m_rq_data;
    bit          m_ub_full;
    int          m_ub_wait;
    logic [31:0] m_ub_addr;
    bit          m_rd, m_wr, m_es, m_er;

    function automatic bit m_rsp_ready();
        if (m_trig) return 0;
        if (rsp_kind >= 3'd4) return 1;
        if (m_st == 1) return (rsp_kind == 3'd1) || (rsp_kind == 3'd2) || (rsp_kind == 3'd3);
        if (m_st == 2) return (rsp_kind == 3'd0) || (rsp_kind == 3'd3);
        return 0;
    endfunction

    always @(posedge clk) begin
        bit sr, sf, sg, rr, rf, take, ub_load;
        int ost;
        if (!rst_n) begin
            m_st = 0; m_bal = 0; m_trig = 0; m_taddr = 0; m_hold = 0;
            m_rq_full = 0; m_rq_wait = 0; m_rq_kind = 0; m_rq_addr = 0; m_rq_len = 0; m_rq_data = 0;
            m_ub_full = 0; m_ub_wait = 0; m_ub_addr = 0;
            m_rd = 0; m_wr = 0; m_es = 0; m_er = 0;
        end else begin
            ost  = m_st;
            sr   = (m_st == 0) && !m_rq_full;
            sf   = seq_valid && sr;
            sg   = seq_kind < 2'd2;
            rr   = m_rsp_ready();
            rf   = rsp_valid && rr;
            take = m_trig && (m_st == 1 || (m_st == 2 && !m_ub_full));
            ub_load = take && (m_st == 2);
            m_rd = 0; m_wr = 0; m_es = 0;
            m_er = rf && (rsp_kind >= 3'd4);
            // request port with delay
            if (sf && sg) begin
                m_rq_full = 1; m_rq_wait = LATQ; m_rq_kind = (seq_kind == 2'd1);
                m_rq_addr = seq_addr; m_rq_len = seq_len; m_rq_data = seq_data;
            end else if (m_rq_full) begin
                if (m_rq_wait > 0) m_rq_wait--;
                else if (req_ready) m_rq_full = 0;
            end
            // unblock port with delay
            if (ub_load) begin
                m_ub_full = 1; m_ub_wait = LATU; m_ub_addr = m_taddr;
            end else if (m_ub_full) begin
                if (m_ub_wait > 0) m_ub_wait--;
                else if (unb_ready) m_ub_full = 0;
            end
            // ack balance
            if (sf && sg) begin
                m_bal = 0; m_trig = 0;
            end else begin
                if (rf && (rsp_kind == 3'd0 || rsp_kind == 3'd3)) begin
                    m_bal = m_bal - rsp_acks;
                    if (m_bal == 0) m_trig = 1;
                end
                if (take) m_trig = 0;
            end
            // transaction state
            if (ost == 0 && sf) begin
                if (seq_kind == 2'd0) begin m_st = 1; m_taddr = seq_addr; m_hold = 0; end
                else if (seq_kind == 2'd1) begin m_st = 2; m_taddr = seq_addr; end
                else m_es = 1;
            end else if (ost == 1) begin
                if (rf && (rsp_kind == 3'd1 || rsp_kind == 3'd2)) begin
                    m_hold = rsp_data; m_rd = 1; m_st = 0;
                end else if (take) begin
                    m_rd = 1; m_st = 0;
                end
            end else if (ost == 2 && take) begin
                m_wr = 1; m_st = 0;
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            chk(seq_ready == ((m_st == 0) && !m_rq_full), "R4 seq_ready", seq_ready, (m_st == 0) && !m_rq_full);
            chk(req_valid == (m_rq_full && m_rq_wait == 0), "R3 req_valid", req_valid, m_rq_full && m_rq_wait == 0);
            if (req_valid) begin
                chk(req_kind == m_rq_kind && req_addr == m_rq_addr, "R2 req kind/addr", {req_kind, req_addr}, {m_rq_kind, m_rq_addr});
                chk(req_len == m_rq_len && req_data == m_rq_data, "R2 req len/data", req_data, m_rq_data);
                chk(req_src == 4'd5, "R2 req_src", req_src, 5);
            end
            chk(rsp_ready == m_rsp_ready(), "R11 rsp_ready", rsp_ready, m_rsp_ready());
            chk(unb_valid == (m_ub_full && m_ub_wait == 0), "R10 unb_valid", unb_valid, m_ub_full && m_ub_wait == 0);
            if (unb_valid) chk(unb_addr == m_ub_addr, "R10 unb_addr", unb_addr, m_ub_addr);
            chk(rd_done == m_rd, "R8 rd_done", rd_done, m_rd);
            chk(rd_data == m_hold, "R8 rd_data", rd_data, m_hold);
            chk(wr_done == m_wr, "R10 wr_done", wr_done, m_wr);
            chk(err_seq == m_es, "R5 err_seq", err_seq, m_es);
            chk(err_rsp == m_er, "R6 err_rsp", err_rsp, m_er);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic seq_push(input logic [1:0] k, input logic [31:0] a, input logic [7:0] l, input logic [63:0] d);
        @(negedge clk);
        seq_kind = k; seq_addr = a; seq_len = l; seq_data = d; seq_valid = 1;
        #1;
        while (!seq_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        seq_valid = 0;
        #1;
    endtask

    task automatic rsp_push(input logic [2:0] k, input logic signed [7:0] n, input logic [63:0] d,
                            input int maxw, output bit acc);
        int w;
        @(negedge clk);
        rsp_kind = k; rsp_acks = n; rsp_data = d; rsp_valid = 1;
        #1;
        w = 0;
        while (!rsp_ready && w < maxw) begin @(negedge clk); #1; w++; end
        acc = rsp_ready;
        @(negedge clk);
        rsp_valid = 0;
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int k;
        bit acc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(seq_ready == 1, "R1 seq_ready", seq_ready, 1);
        chk(req_valid == 0 && unb_valid == 0, "R1 valids", {req_valid, unb_valid}, 0);
        chk(rd_done == 0 && wr_done == 0 && err_seq == 0 && err_rsp == 0, "R1 pulses",
            {rd_done, wr_done, err_seq, err_rsp}, 0);

        // read answered with exclusive data
        seq_push(2'd0, 32'h1000_0040, 8'd64, 64'h0);
        k = 0;
        while (!req_valid && k < 100) begin @(negedge clk); #1; k++; end
        chk(k == LATQ, "R3 request latency", k, LATQ);
        chk(req_kind == 0 && req_addr == 32'h1000_0040 && req_len == 8'd64, "R2 load request",
            req_addr, 32'h1000_0040);
        chk(req_src == 4'd5, "R2 requester id", req_src, 5);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            seq_kind = 2'd1; seq_addr = 32'h2000; seq_valid = 1;
            #1;
            chk(seq_ready == 0, "R4 busy refuses", seq_ready, 0);
        end
        @(negedge clk);
        seq_valid = 0;
        rsp_push(3'd2, 0, 64'h1234_5678_9abc_def0, 20, acc);
        chk(acc, "R8 data accepted", acc, 1);
        chk(rd_done == 1 && rd_data == 64'h1234_5678_9abc_def0, "R8 read data", rd_data, 64'h1234_5678_9abc_def0);

        // write with negative memory ack, then invalidation acks
        @(negedge clk);
        req_ready = 0;
        seq_push(2'd1, 32'h0000_b000, 8'd32, 64'hcafe_f00d_0000_0001);
        repeat (20) @(negedge clk);
        #1;
        chk(req_valid == 1 && req_kind == 1, "R3 request held", {req_valid, req_kind}, 2'b11);
        chk(req_data == 64'hcafe_f00d_0000_0001, "R2 store data", req_data, 64'hcafe_f00d_0000_0001);
        @(negedge clk);
        req_ready = 1;
        rsp_push(3'd0, -8'sd2, 0, 20, acc);
        chk(acc, "R7 mem ack taken", acc, 1);
        rsp_push(3'd3, 8'sd1, 0, 20, acc);
        rsp_push(3'd1, 0, 64'h55, 4, acc);
        chk(!acc, "R11 data in write refused", acc, 0);
        rsp_push(3'd5, 0, 0, 4, acc);
        chk(acc && err_rsp, "R6 bad response", {acc, err_rsp}, 2'b11);
        chk(wr_done == 0, "R7 not yet complete", wr_done, 0);
        @(negedge clk);
        unb_ready = 0;
        rsp_push(3'd3, 8'sd1, 0, 20, acc);
        chk(rsp_ready == 0, "R7 trigger pending stalls", rsp_ready, 0);
        @(negedge clk);
        #1;
        chk(wr_done == 1, "R10 write done", wr_done, 1);
        k = 0;
        while (!unb_valid && k < 100) begin @(negedge clk); #1; k++; end
        chk(k == LATU, "R10 unblock latency", k, LATU);
        chk(unb_addr == 32'h0000_b000, "R10 unblock addr", unb_addr, 32'h0000_b000);

        // second write completes while unblock slot still occupied
        seq_push(2'd1, 32'h0000_c000, 8'd8, 64'h77);
        rsp_push(3'd0, 8'sd0, 0, 20, acc);
        repeat (6) begin
            @(negedge clk); #1;
            chk(wr_done == 0, "R10 trigger waits on slot", wr_done, 0);
        end
        @(negedge clk);
        unb_ready = 1;
        k = 0;
        #1;
        while (!wr_done && k < 10) begin @(negedge clk); #1; k++; end
        chk(k == 2, "R10 take after slot frees", k, 2);
        k = 0;
        while (!(unb_valid && unb_addr == 32'h0000_c000) && k < 100) begin @(negedge clk); #1; k++; end
        chk(unb_addr == 32'h0000_c000, "R10 second unblock", unb_addr, 32'h0000_c000);

        // illegal sequencer kind
        while (!seq_ready) begin @(negedge clk); #1; end
        seq_push(2'd2, 32'h9, 8'd1, 64'h1);
        chk(err_seq == 1 && seq_ready == 1, "R5 illegal kind", {err_seq, seq_ready}, 2'b11);

        // legal response in idle is refused
        rsp_push(3'd3, 8'sd1, 0, 4, acc);
        chk(!acc, "R11 idle refuses", acc, 0);

        // read completed by invalidation acks only
        seq_push(2'd0, 32'h0000_d000, 8'd16, 64'h0);
        rsp_push(3'd3, 8'sd1, 0, 40, acc);
        rsp_push(3'd0, 8'sd0, 0, 4, acc);
        chk(!acc, "R11 mem ack in read refused", acc, 0);
        rsp_push(3'd3, -8'sd1, 0, 40, acc);
        @(negedge clk);
        #1;
        chk(rd_done == 1 && rd_data == 64'h0, "R9 read via acks", {rd_done, rd_data}, {1'b1, 64'h0});

        // read answered with plain data
        while (!seq_ready) begin @(negedge clk); #1; end
        seq_push(2'd0, 32'h0000_e000, 8'd64, 64'h0);
        rsp_push(3'd1, 0, 64'hfeed_beef_0000_0042, 40, acc);
        chk(rd_done == 1 && rd_data == 64'hfeed_beef_0000_0042, "R6 plain data decodes",
            rd_data, 64'hfeed_beef_0000_0042);

        repeat (40) @(negedge clk);
        finish_run();
    end

endmodule